// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers sixteen peripheral interrupt causes into one 16-bit pending register. Software can read that register and clear it one bit at a time. Each source has an enable bit and a 3-bit priority level. Among the sources that are both pending and enabled, the block finds the highest-level one. It offers that source to the processor core only while the core's global interrupt enable is high and the source's level is strictly above the core's current interrupt level.

The upper eight sources, bits 15 to 8, come from internal peripherals and are always captured on a rising edge. The lower eight sources, bits 7 to 0, can each be switched to level capture. In level capture the pending bit simply mirrors the input and ignores software clears. The core sees a registered request line, the 4-bit number of the winning source and that source's level. When the core takes an interrupt, software clears the pending bit. The request stays up until that happens.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every pending bit, enable bit, capture-mode bit and level field is 0. `irq_req`, `irq_vec` and `irq_lvl` are 0, and every register address reads 0.
- R2: In edge capture, a rising edge on a source input sets its pending bit whatever its enable bit or level. An input held high sets the bit only once, so a clear made while the input stays high is final.
- R3: Writing the pending register clears each bit written as 1 and leaves each bit written as 0. If a rising edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A capture-mode bit of 1 puts source 0..7 into level capture. Its pending bit then equals the input sampled at the previous clock edge, and writing 1 to it does not clear it. Capture-mode bits 15..8 always read 0 and cannot be set.
- R5: A source whose enable bit is 0 never produces a request, although its pending bit is still set.
- R6: When `core_ie` is 0, no request is raised.
- R7: A request is raised only when the winner's level is strictly greater than `core_il`. A source with level 0 therefore never interrupts.
- R8: Among pending, enabled sources the highest level wins. When levels are equal, the lower source index wins.
- R9: `irq_req`, `irq_vec` and `irq_lvl` are registered. They change one clock after the pending bit they depend on. They stay asserted while that pending bit remains set. With no request, `irq_vec` and `irq_lvl` are 0.
- R10: Register addresses are as follows. 0 is the pending register and 1 is the enables. 2 is the capture modes. 3 is unused, reads 0 and ignores writes. Addresses 4 to 7 hold the levels: address 4+j, bits 4k+2..4k, is the level of source 4j+k, and bit 4k+3 reads 0. Read data is registered and shows the addressed register one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| src_in | input | 16 | Interrupt cause inputs, one per source |
| core_ie | input | 1 | Core global interrupt enable |
| core_il | input | 3 | Core current interrupt level |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
The checker compares each request with the values of `core_ie`, `core_il`, the enables and the levels one clock earlier. This assumes those inputs are synchronous to `clk` and held stable around the sampling edge. The level-capture check assumes every source input is a clean synchronous signal, because the block has no synchronizer. The stimulus changes inputs only on falling clock edges. It never changes `core_ie` or `core_il` while it samples a request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_AW    = 3;
  localparam int LVL_FLD_W = 4;

  localparam logic [REG_AW-1:0] RA_FLAG     = 3'd0;
  localparam logic [REG_AW-1:0] RA_ENABLE   = 3'd1;
  localparam logic [REG_AW-1:0] RA_MODE     = 3'd2;
  localparam logic [REG_AW-1:0] RA_LVL_BASE = 3'd4;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_EXT = 8,
  parameter int LVL_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [REG_AW-1:0]        addr,
  input  logic [NUM_SRC-1:0]       wr_data,
  input  logic [NUM_SRC-1:0]       flags,
  output logic [NUM_SRC-1:0]       rd_data,
  output logic [NUM_SRC-1:0]       flag_clr,
  output logic [NUM_SRC-1:0]       en_q,
  output logic [NUM_SRC-1:0]       mode_q,
  output logic [NUM_SRC*LVL_W-1:0] lvl_flat
);
  localparam int PER_WORD  = NUM_SRC / LVL_FLD_W;
  localparam int LVL_WORDS = NUM_SRC / PER_WORD;
  localparam logic [NUM_SRC-1:0] EXT_MASK =
    {{(NUM_SRC-NUM_EXT){1'b0}}, {NUM_EXT{1'b1}}};

  logic [LVL_W-1:0]  lvl_q [NUM_SRC];
  logic              is_lvl;
  logic [REG_AW-1:0] lvl_word;
  logic [NUM_SRC-1:0] lvl_rd;

  assign is_lvl   = (addr >= RA_LVL_BASE) &&
                    (int'(addr - RA_LVL_BASE) < LVL_WORDS);
  assign lvl_word = addr - RA_LVL_BASE;
  assign flag_clr = (wr_en && addr == RA_FLAG) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
    end else if (wr_en) begin
      if (addr == RA_ENABLE) en_q <= wr_data;
      if (addr == RA_MODE)   mode_q <= wr_data & EXT_MASK;
      if (is_lvl) begin
        for (int k = 0; k < PER_WORD; k++)
          lvl_q[int'(lvl_word) * PER_WORD + k] <= wr_data[k*LVL_FLD_W +: LVL_W];
      end
    end
  end

  always_comb begin
    lvl_rd = '0;
    if (is_lvl) begin
      for (int k = 0; k < PER_WORD; k++)
        lvl_rd[k*LVL_FLD_W +: LVL_W] = lvl_q[int'(lvl_word) * PER_WORD + k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    rd_data <= '0;
    else if (addr == RA_FLAG)   rd_data <= flags;
    else if (addr == RA_ENABLE) rd_data <= en_q;
    else if (addr == RA_MODE)   rd_data <= mode_q;
    else                        rd_data <= lvl_rd;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pack
    assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q[g];
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 16,
  parameter int NUM_EXT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] mode,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] flag_q
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] rise;

  assign rise = src_in & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_in;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    if (g < NUM_EXT) begin : g_ext
      always_ff @(posedge clk) begin
        if (rst)          flag_q[g] <= 1'b0;
        else if (mode[g]) flag_q[g] <= src_in[g];
        else              flag_q[g] <= rise[g] | (flag_q[g] & ~clr[g]);
      end
    end else begin : g_int
      always_ff @(posedge clk) begin
        if (rst) flag_q[g] <= 1'b0;
        else     flag_q[g] <= rise[g] | (flag_q[g] & ~clr[g]);
      end
      logic unused_mode;
      assign unused_mode = mode[g];
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       cand,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!found || lvl_flat[i*LVL_W +: LVL_W] >= win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_EXT = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               core_ie,
  input  logic [LVL_W-1:0]   core_il,
  output logic               irq_req,
  output logic [IDX_W-1:0]   irq_vec,
  output logic [LVL_W-1:0]   irq_lvl
);
  logic [NUM_SRC-1:0]       flag_q;
  logic [NUM_SRC-1:0]       flag_clr;
  logic [NUM_SRC-1:0]       en_q;
  logic [NUM_SRC-1:0]       mode_q;
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic                     found;
  logic [IDX_W-1:0]         win_idx;
  logic [LVL_W-1:0]         win_lvl;
  logic                     fire;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata),
    .flags(flag_q), .rd_data(reg_rdata), .flag_clr(flag_clr),
    .en_q(en_q), .mode_q(mode_q), .lvl_flat(lvl_flat)
  );

  irq_flag_bank #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) u_flags (
    .clk(clk), .rst(rst), .src_in(src_in), .mode(mode_q),
    .clr(flag_clr), .flag_q(flag_q)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .cand(flag_q & en_q), .lvl_flat(lvl_flat),
    .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign fire = found && core_ie && (win_lvl > core_il);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
    end else begin
      irq_req <= fire;
      irq_vec <= fire ? win_idx : '0;
      irq_lvl <= fire ? win_lvl : '0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_SRC = 16,
  parameter int NUM_EXT = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_SRC-1:0]       src_in,
  input logic                     core_ie,
  input logic [LVL_W-1:0]         core_il,
  input logic                     irq_req,
  input logic [IDX_W-1:0]         irq_vec,
  input logic [LVL_W-1:0]         irq_lvl,
  input logic [NUM_SRC-1:0]       flags,
  input logic [NUM_SRC-1:0]       en,
  input logic [NUM_SRC-1:0]       mode,
  input logic [NUM_SRC*LVL_W-1:0] lvl_flat
);
  logic [NUM_SRC-1:0]       en_d, flags_d;
  logic [NUM_SRC*LVL_W-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d <= '0; flags_d <= '0; lvl_d <= '0;
    end else begin
      en_d <= en; flags_d <= flags; lvl_d <= lvl_flat;
    end
  end

  AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(core_ie)); // R6
  AST_LVL_ABOVE_IL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl > $past(core_il))); // R7
  AST_WINNER_PENDING_ENABLED: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (en_d[irq_vec] && flags_d[irq_vec])); // R5
  AST_WINNER_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl == lvl_d[irq_vec*LVL_W +: LVL_W])); // R8
  AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0 && irq_lvl == '0)); // R9

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_lvl
    AST_LEVEL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
      $past(mode[g]) |-> (flags[g] == $past(src_in[g]))); // R4
  end
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .src_in(src_in), .core_ie(core_ie), .core_il(core_il),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
  .flags(flag_q), .en(en_q), .mode(mode_q), .lvl_flat(lvl_flat)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] src_in = '0;
  logic        core_ie = 1'b0;
  logic [2:0]  core_il = '0;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic [2:0]  irq_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
    .core_ie(core_ie), .core_il(core_il), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [15:0] pulse;
    logic [15:0] en;
    logic        ie;
    logic [2:0]  il;
    logic        req;
    logic [3:0]  vec;
    logic [2:0]  lvl;
  } vec_t;

  // Levels programmed: source i has level i mod 8.
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0004, 16'hFFFF, 1'b1, 3'd0, 1'b1, 4'd2,  3'd2},
    '{16'h0004, 16'h0000, 1'b1, 3'd0, 1'b0, 4'd0,  3'd0},
    '{16'h0004, 16'hFFFF, 1'b0, 3'd0, 1'b0, 4'd0,  3'd0},
    '{16'h0004, 16'hFFFF, 1'b1, 3'd2, 1'b0, 4'd0,  3'd0},
    '{16'h0004, 16'hFFFF, 1'b1, 3'd1, 1'b1, 4'd2,  3'd2},
    '{16'h0404, 16'hFFFF, 1'b1, 3'd0, 1'b1, 4'd2,  3'd2},
    '{16'h8004, 16'hFFFF, 1'b1, 3'd0, 1'b1, 4'd15, 3'd7},
    '{16'h8004, 16'h0004, 1'b1, 3'd0, 1'b1, 4'd2,  3'd2},
    '{16'h0081, 16'hFFFF, 1'b1, 3'd6, 1'b1, 4'd7,  3'd7},
    '{16'h0001, 16'hFFFF, 1'b1, 3'd0, 1'b0, 4'd0,  3'd0},
    '{16'h00F0, 16'h0070, 1'b1, 3'd3, 1'b1, 4'd6,  3'd6},
    '{16'h1200, 16'hFFFF, 1'b1, 3'd4, 1'b0, 4'd0,  3'd0},
    '{16'h4040, 16'hFFFF, 1'b1, 3'd0, 1'b1, 4'd6,  3'd6}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    tick(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_req", 32'(irq_req), 0);
    check("R1 irq_vec", 32'(irq_vec), 0);
    check("R1 irq_lvl", 32'(irq_lvl), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d", a), 32'(d), 0);
    end

    // R10 register map
    wr(3'd1, 16'hA5C3); rd(3'd1, d); check("R10 enable readback", 32'(d), 32'hA5C3);
    wr(3'd2, 16'hFFFF); rd(3'd2, d); check("R4 mode upper bits", 32'(d), 32'h00FF);
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'hFFFF); rd(3'd4, d); check("R10 level pad bits", 32'(d), 32'h7777);
    wr(3'd3, 16'h1234); rd(3'd3, d); check("R10 unused addr", 32'(d), 0);
    wr(3'd4, 16'h3210); wr(3'd5, 16'h7654);
    wr(3'd6, 16'h3210); wr(3'd7, 16'h7654);
    rd(3'd5, d); check("R10 level word 5", 32'(d), 32'h7654);
    rd(3'd6, d); check("R10 level word 6", 32'(d), 32'h3210);

    // Arbitration vector table: R2 R5 R6 R7 R8
    foreach (VECS[i]) begin
      wr(3'd0, 16'hFFFF);
      wr(3'd1, VECS[i].en);
      core_ie = VECS[i].ie;
      core_il = VECS[i].il;
      src_in = VECS[i].pulse;
      tick(1);
      src_in = '0;
      tick(1);
      check($sformatf("R8 vec%0d req", i), 32'(irq_req), 32'(VECS[i].req));
      check($sformatf("R8 vec%0d index", i), 32'(irq_vec), 32'(VECS[i].vec));
      check($sformatf("R7 vec%0d level", i), 32'(irq_lvl), 32'(VECS[i].lvl));
      rd(3'd0, d);
      check($sformatf("R2 vec%0d flags", i), 32'(d), 32'(VECS[i].pulse));
    end

    // R9 registered timing and persistence
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'hFFFF);
    core_ie = 1'b1; core_il = 3'd0;
    tick(1);
    src_in = 16'h0200;
    tick(1);
    check("R9 no req one cycle after edge", 32'(irq_req), 0);
    tick(1);
    check("R9 req two cycles after edge", 32'(irq_req), 1);
    check("R9 vec", 32'(irq_vec), 9);
    check("R9 lvl", 32'(irq_lvl), 1);
    src_in = '0;
    tick(3);
    check("R9 req held while pending", 32'(irq_req), 1);
    wr(3'd0, 16'h0200);
    check("R9 req one cycle after clear", 32'(irq_req), 1);
    tick(1);
    check("R9 req drop after clear", 32'(irq_req), 0);
    check("R9 idle vec zero", 32'(irq_vec), 0);

    // R2 held-high input sets once
    src_in = 16'h0008;
    tick(2);
    wr(3'd0, 16'h0008);
    tick(1);
    rd(3'd0, d);
    check("R2 held high no re-set", 32'(d), 0);
    src_in = '0;
    tick(1);

    // R3 write 0 keeps, write 1 clears, set beats clear
    src_in = 16'h0002; tick(1); src_in = '0; tick(1);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); check("R3 write zero keeps", 32'(d), 32'h0002);
    wr(3'd0, 16'h0002);
    rd(3'd0, d); check("R3 write one clears", 32'(d), 0);
    src_in = 16'h0020;
    wr(3'd0, 16'h0020);
    src_in = '0;
    rd(3'd0, d); check("R3 set beats clear", 32'(d), 32'h0020);
    wr(3'd0, 16'hFFFF);

    // R4 level capture on source 6
    wr(3'd2, 16'h0040);
    src_in = 16'h0040;
    tick(2);
    check("R4 level req", 32'(irq_req), 1);
    check("R4 level vec", 32'(irq_vec), 6);
    wr(3'd0, 16'h0040);
    rd(3'd0, d); check("R4 clear ignored", 32'(d), 32'h0040);
    src_in = '0;
    tick(1);
    rd(3'd0, d); check("R4 follows input low", 32'(d), 0);
    tick(1);
    check("R4 req gone", 32'(irq_req), 0);

    done = 1'b1;
    finish_run();
  end
endmodule